// File: doc/BRIEF.md
# Pulse-Width Modulator with Disabled Hold

This block drives a single output that is high for a programmable number of clocks in every modulation period. The period is fixed at elaboration: it lasts one clock fewer than the level count parameter, so a level count of N gives N distinct brightness or power steps from fully off to fully on. The on-time arrives on a `duration` input. The block samples it only at the start of each period, so a new value never cuts a period short or stretches it.

An `enable` input selects between modulating and holding. While `enable` is low, the period counter is held at zero and the output sits at a static level. That level is low when `duration` is zero and high for any nonzero `duration`. When `enable` rises again, a fresh period starts at once from count zero. The output comes from a register. An asynchronous active-low reset clears the output and the counter.

Top module: `pwm_gen`

## Requirements
- R1: The period is P = NUM_LEVELS − 1 clocks. The counter and `duration` are both $clog2(NUM_LEVELS) bits wide. With `enable` high and `duration` held at d (0 ≤ d ≤ P), every window of P consecutive output cycles has exactly d high cycles, and the high cycles come first in each period.
- R2: A `duration` above P behaves like `duration` = P, so the output stays high.
- R3: When `duration` equals P and `enable` is high, the output stays high across period boundaries with no low cycle.
- R4: When `duration` is 0 and `enable` is high, the output stays low.
- R5: While `enable` is low, the counter is held at zero. On the first clock edge after `enable` rises, a new period begins: the output is high for the first d cycles of that period and then low.
- R6: While `enable` is low, the output is low if `duration` is 0 and high for any nonzero `duration`.
- R7: A change on `duration` in the middle of a period has no effect until the next period starts. The value is sampled in the cycle where the counter is at zero.
- R8: The output is registered. A change on the inputs shows on `pwm_out` only after the next rising clock edge.
- R9: Asserting `rst_n` low forces `pwm_out` low at once and clears the counter, so the first period after release starts from count zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High: modulate; low: hold a static level |
| duration | input | $clog2(NUM_LEVELS) | On-time in clocks per period |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The output register adds one clock of latency. A level held while disabled is therefore due on the first rising edge after `enable` or `duration` changes. A new `duration` under modulation takes effect from the next counter wrap, so a new duty cycle is fully visible no later than P + 1 edges after the change. The bench drives and samples at falling edges. It lets 2P + 2 cycles pass before it counts high cycles over a P-cycle window. Its directed sequences start from a known counter state (just after re-enable or reset release) and compare the output edge by edge from the first rising edge onward.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Modulation period in clocks for a given level count.
    function automatic int period_of(input int levels);
        return levels - 1;
    endfunction

    // Width of the period counter and of the on-time input.
    function automatic int cnt_width(input int levels);
        return (levels < 2) ? 1 : $clog2(levels);
    endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_pkg::*;
#(
    parameter int NUM_LEVELS = 5,
    localparam int CW     = cnt_width(NUM_LEVELS),
    localparam int PERIOD = period_of(NUM_LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          start
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;                       // held at zero while disabled
        end else if (st_q.cnt == CW'(PERIOD - 1)) begin
            st_d.cnt = '0;                       // wrap at end of period
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign start = (st_q.cnt == '0);

endmodule

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold
    import pwm_pkg::*;
#(
    parameter int NUM_LEVELS = 5,
    localparam int CW = cnt_width(NUM_LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          start,
    input  logic [CW-1:0] duration,
    output logic [CW-1:0] eff_duty,
    output logic [CW-1:0] held_duty
);

    typedef struct packed {
        logic [CW-1:0] duty;
    } hold_state_t;

    hold_state_t st_d, st_q;

    // At a period start the live input applies; otherwise the sampled value.
    always_comb begin
        eff_duty = start ? duration : st_q.duty;
        st_d     = st_q;
        if (run) begin
            st_d.duty = eff_duty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_duty = st_q.duty;

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pkg::*;
#(
    parameter int NUM_LEVELS = 5,
    localparam int CW = cnt_width(NUM_LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] eff_duty,
    input  logic [CW-1:0] duration,
    output logic          pwm_out
);

    typedef struct packed {
        logic out;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            // High during the first eff_duty counts; a duty at or above the
            // period keeps every count below it, so the output never drops.
            st_d.out = (cnt < eff_duty);
        end else begin
            st_d.out = (duration != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_out = st_q.out;

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
#(
    parameter int NUM_LEVELS = 5,
    localparam int CW = cnt_width(NUM_LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] duration,
    output logic          pwm_out
);

    logic [CW-1:0] cnt_q;
    logic          period_start;
    logic [CW-1:0] eff_duty;
    logic [CW-1:0] dur_q;

    pwm_period_ctr #(.NUM_LEVELS(NUM_LEVELS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .cnt   (cnt_q),
        .start (period_start)
    );

    pwm_duty_hold #(.NUM_LEVELS(NUM_LEVELS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .start     (period_start),
        .duration  (duration),
        .eff_duty  (eff_duty),
        .held_duty (dur_q)
    );

    pwm_out_stage #(.NUM_LEVELS(NUM_LEVELS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .cnt      (cnt_q),
        .eff_duty (eff_duty),
        .duration (duration),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
    import pwm_pkg::*;
#(
    parameter int NUM_LEVELS = 5,
    localparam int CW     = cnt_width(NUM_LEVELS),
    localparam int PERIOD = period_of(NUM_LEVELS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [CW-1:0] duration,
    input logic          pwm_out,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] dur_hold
);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(PERIOD)); // R1

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (cnt == CW'(PERIOD - 1)) |=> (cnt == '0)); // R1

    AST_FULL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (cnt == '0) && (duration >= CW'(PERIOD)) |=> pwm_out); // R3

    AST_FULL_MID: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (cnt != '0) && (dur_hold >= CW'(PERIOD)) |=> pwm_out); // R2

    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (cnt == '0) && (duration == '0) |=> !pwm_out); // R4

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0)); // R5

    AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pwm_out == ($past(duration) != '0))); // R6

    AST_DUTY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (cnt == '0) |=> (dur_hold == $past(duration))); // R7

    AST_DUTY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (cnt != '0) |=> $stable(dur_hold)); // R7

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> !pwm_out); // R9

endmodule

bind pwm_gen pwm_gen_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .duration (duration),
    .pwm_out  (pwm_out),
    .cnt      (cnt_q),
    .dur_hold (dur_q)
);

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;

    localparam int NL = 5;
    localparam int P  = NL - 1;
    localparam int CW = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] duration = '0;
    logic          pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwm_gen #(.NUM_LEVELS(NL)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .duration (duration),
        .pwm_out  (pwm_out)
    );

    typedef struct packed {
        logic          en;
        logic [CW-1:0] dur;
        logic [3:0]    highs;
        logic [3:0]    req;
    } vec_t;

    // Expected high count over one P-cycle window after settling.
    localparam vec_t TBL [12] = '{
        '{1'b1, 3'd0, 4'd0, 4'd4},
        '{1'b1, 3'd1, 4'd1, 4'd1},
        '{1'b1, 3'd2, 4'd2, 4'd1},
        '{1'b1, 3'd3, 4'd3, 4'd1},
        '{1'b1, 3'd4, 4'd4, 4'd3},
        '{1'b1, 3'd5, 4'd4, 4'd2},
        '{1'b1, 3'd6, 4'd4, 4'd2},
        '{1'b1, 3'd7, 4'd4, 4'd2},
        '{1'b0, 3'd0, 4'd0, 4'd6},
        '{1'b0, 3'd3, 4'd4, 4'd6},
        '{1'b0, 3'd7, 4'd4, 4'd6},
        '{1'b1, 3'd2, 4'd2, 4'd5}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Compare the output after each of the next edges against a bit pattern.
    task automatic expect_seq(input string req, input int len, input logic [15:0] pat);
        for (int k = 0; k < len; k++) begin
            tick();
            chk(req, int'(pwm_out), int'(pat[k]));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state, even with a full-on request pending
        enable   = 1'b1;
        duration = 3'd4;
        repeat (3) tick();
        chk("R9", int'(pwm_out), 0);
        rst_n = 1'b1;

        // Table walk: steady high counts per period window
        for (int i = 0; i < 12; i++) begin
            int hi;
            enable   = TBL[i].en;
            duration = TBL[i].dur;
            repeat (2 * P + 2) tick();
            hi = 0;
            for (int k = 0; k < P; k++) begin
                tick();
                if (pwm_out) hi++;
            end
            chk($sformatf("R%0d", int'(TBL[i].req)), hi, int'(TBL[i].highs));
        end

        // R3: full duty, no low cycle across several boundaries
        enable   = 1'b1;
        duration = 3'd4;
        repeat (2 * P + 2) tick();
        begin
            int lows = 0;
            for (int k = 0; k < 3 * P; k++) begin
                tick();
                if (!pwm_out) lows++;
            end
            chk("R3", lows, 0);
        end

        // R6 and R5: hold high while disabled, restart from count zero
        enable   = 1'b0;
        duration = 3'd2;
        repeat (3) tick();
        chk("R6", int'(pwm_out), 1);
        enable = 1'b1;
        expect_seq("R5", 8, 16'b0000_0000_0011_0011);

        // R7: mid-period change waits for the next period
        enable   = 1'b0;
        duration = 3'd1;
        repeat (3) tick();
        enable = 1'b1;
        tick();
        chk("R7", int'(pwm_out), 1);
        duration = 3'd3;
        expect_seq("R7", 7, 16'b0000_0000_0011_1000);

        // R8: registered output, no change before the next edge
        enable   = 1'b0;
        duration = 3'd0;
        repeat (3) tick();
        chk("R6", int'(pwm_out), 0);
        duration = 3'd3;
        #1;
        chk("R8", int'(pwm_out), 0);
        tick();
        chk("R8", int'(pwm_out), 1);

        // R9: reset during a run forces low at once and clears the counter
        enable   = 1'b1;
        duration = 3'd4;
        repeat (2 * P) tick();
        rst_n = 1'b0;
        #1;
        chk("R9", int'(pwm_out), 0);
        duration = 3'd2;
        tick();
        rst_n = 1'b1;
        expect_seq("R9", 8, 16'b0000_0000_0011_0011);

        // R4: zero duty stays low with modulation running
        duration = 3'd0;
        repeat (2 * P + 2) tick();
        begin
            int highs = 0;
            for (int k = 0; k < 2 * P; k++) begin
                tick();
                if (pwm_out) highs++;
            end
            chk("R4", highs, 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule